// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block takes a small processor core out of normal execution and parks it in a halted debug state. Two sources can start entry: a debug request from the host command path and a pulse from the breakpoint comparators. Either source is accepted only while the core runs normally.

Once a trigger is taken, the block runs a fixed sequence that resembles interrupt entry. It takes one step per clock, in this order:

1. Block the next program fetch.
2. Push the return address to the stack.
3. Load a fixed debug vector into the instruction pointer.
4. Clear the global interrupt enable.
5. Halt the core.

For as long as debug mode lasts, the timer clock enables and the watchdog clock enable are held low. Further triggers have no effect during that time. A resume input brings the core back to normal execution. Resume does not restore the interrupt enable, so software has to set it again.

The stack, the comparators and the datapath are modelled as plain ports. The interrupt enable register is kept inside the block, with a write port for software, so that interrupt grants can be masked.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: When host_dbg_req or bkpt_hit is high at a clock edge while debug_active is 0, debug_active and fetch_block are both 1 after that edge. fetch_block stays high for exactly one cycle.
- R2: When both triggers are high in the same cycle, exactly one entry sequence runs, with exactly one stack push.
- R3: In the second entry cycle stk_push is high for one cycle. During that cycle stk_wdata equals the value pc_next had in the cycle the trigger was sampled.
- R4: In the third entry cycle ip_load is high for one cycle, with ip_value equal to 16'h8010.
- R5: In the fourth entry cycle ige_clr is high and ige reads 0 from the next cycle on. halt rises in the fifth cycle and holds until a resume is accepted.
- R6: While debug_active is 1, both triggers are ignored. halt stays high and no further stack push occurs.
- R7: Every bit of tmr_clk_en, and also wdt_clk_en, is 0 whenever debug_active is 1 and 1 whenever debug_active is 0.
- R8: irq_grant is 1 exactly when irq_req is 1, ige is 1 and debug_active is 0. No grant is therefore possible in debug mode.
- R9: A resume sampled while halt is 1 clears debug_active and halt and re-enables all clock enables after the next edge, while ige stays 0. A resume during the first four entry steps is ignored.
- R10: After reset, debug_active, halt, fetch_block, stk_push, ip_load, ige_clr and ige are 0, and all clock enables are 1.
- R11: An ige_wr pulse loads ige_wdata into ige at the next edge. In the clearing step of entry, the clear takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_dbg_req | input | 1 | Debug request from the host command path |
| bkpt_hit | input | 1 | Breakpoint match pulse |
| resume | input | 1 | Return to normal execution |
| pc_next | input | AW | Return address offered by the core |
| ige_wr | input | 1 | Software write strobe for the interrupt enable |
| ige_wdata | input | 1 | Value written to the interrupt enable |
| irq_req | input | 1 | Pending interrupt request |
| debug_active | output | 1 | Debug mode flag |
| fetch_block | output | 1 | Suppress the next program fetch |
| stk_push | output | 1 | Stack write strobe |
| stk_wdata | output | AW | Return address for the stack |
| ip_load | output | 1 | Instruction pointer load strobe |
| ip_value | output | AW | Debug vector for the instruction pointer |
| ige_clr | output | 1 | Interrupt enable clear step |
| ige | output | 1 | Global interrupt enable state |
| irq_grant | output | 1 | Interrupt grant |
| halt | output | 1 | Core halt |
| tmr_clk_en | output | NUM_TIMERS | Per-timer clock enables |
| wdt_clk_en | output | 1 | Watchdog clock enable |

## Verification
A trigger sampled at edge N produces fetch_block after edge N, stk_push after edge N+1, ip_load after edge N+2, ige_clr after edge N+3, and halt with ige at 0 after edge N+4. A resume or an ige write sampled at an edge shows its effect one edge later. The clock enables and irq_grant follow debug_active in the same cycle. The bench drives inputs on falling edges and samples outputs on the falling edge that follows each rising edge, stepping one edge per entry step. It also counts stack pushes on every falling edge, which confirms that a single entry is made for simultaneous triggers and that no pushes occur on retriggers.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
   localparam int NSTEP    = 5;
   localparam int ST_FETCH = 0;
   localparam int ST_PUSH  = 1;
   localparam int ST_VEC   = 2;
   localparam int ST_IGE   = 3;
   localparam int ST_HALT  = 4;
   typedef logic [NSTEP-1:0] step_t;
endpackage

// File: rtl/dbg_trig_arb.sv
module dbg_trig_arb (
   input  logic host_req,
   input  logic bkpt,
   input  logic idle,
   output logic start
);
   // both sources merge into a single start; one entry however many fire
   assign start = idle & (host_req | bkpt);
endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq
   import dbg_entry_pkg::*;
#(
   parameter int          AW      = 16,
   parameter logic [AW-1:0] DBG_VEC = AW'(16'h8010)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          resume,
   input  logic [AW-1:0] pc_next,
   output logic          idle,
   output logic          fetch_block,
   output logic          stk_push,
   output logic [AW-1:0] stk_wdata,
   output logic          ip_load,
   output logic [AW-1:0] ip_value,
   output logic          ige_clr,
   output logic          halt
);
   step_t         step_q, step_d;
   logic [AW-1:0] ret_q;

   always_comb begin
      step_d = step_q;
      if (step_q == '0) begin
         if (start) step_d = step_t'(1) << ST_FETCH;
      end else if (step_q[ST_HALT]) begin
         if (resume) step_d = '0;
      end else begin
         step_d = step_q << 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         ret_q  <= '0;
      end else begin
         step_q <= step_d;
         if (start) ret_q <= pc_next;
      end
   end

   assign idle        = (step_q == '0);
   assign fetch_block = step_q[ST_FETCH];
   assign stk_push    = step_q[ST_PUSH];
   assign stk_wdata   = step_q[ST_PUSH] ? ret_q : '0;
   assign ip_load     = step_q[ST_VEC];
   assign ip_value    = step_q[ST_VEC] ? DBG_VEC : '0;
   assign ige_clr     = step_q[ST_IGE];
   assign halt        = step_q[ST_HALT];
endmodule

// File: rtl/dbg_irq_ctl.sv
module dbg_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wr,
   input  logic wdata,
   input  logic active,
   input  logic irq_req,
   output logic ige,
   output logic irq_grant
);
   logic ige_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ige_q <= 1'b0;
      else if (clr) ige_q <= 1'b0;
      else if (wr)  ige_q <= wdata;
   end
   assign ige       = ige_q;
   assign irq_grant = irq_req & ige_q & ~active;
endmodule

// File: rtl/dbg_clk_gate.sv
module dbg_clk_gate #(
   parameter int NUM_TIMERS = 4
) (
   input  logic                  active,
   output logic [NUM_TIMERS-1:0] tmr_en,
   output logic                  wdt_en
);
   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
      assign tmr_en[i] = ~active;
   end
   assign wdt_en = ~active;
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
   parameter int            AW         = 16,
   parameter int            NUM_TIMERS = 4,
   parameter logic [AW-1:0] DBG_VEC    = AW'(16'h8010)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_dbg_req,
   input  logic                  bkpt_hit,
   input  logic                  resume,
   input  logic [AW-1:0]         pc_next,
   input  logic                  ige_wr,
   input  logic                  ige_wdata,
   input  logic                  irq_req,
   output logic                  debug_active,
   output logic                  fetch_block,
   output logic                  stk_push,
   output logic [AW-1:0]         stk_wdata,
   output logic                  ip_load,
   output logic [AW-1:0]         ip_value,
   output logic                  ige_clr,
   output logic                  ige,
   output logic                  irq_grant,
   output logic                  halt,
   output logic [NUM_TIMERS-1:0] tmr_clk_en,
   output logic                  wdt_clk_en
);
   if (AW < 8)         $error("AW must be at least 8");
   if (NUM_TIMERS < 1) $error("NUM_TIMERS must be at least 1");

   logic idle, start;

   dbg_trig_arb u_arb (
      .host_req(host_dbg_req), .bkpt(bkpt_hit), .idle(idle), .start(start)
   );

   dbg_entry_seq #(.AW(AW), .DBG_VEC(DBG_VEC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
      .pc_next(pc_next), .idle(idle), .fetch_block(fetch_block),
      .stk_push(stk_push), .stk_wdata(stk_wdata), .ip_load(ip_load),
      .ip_value(ip_value), .ige_clr(ige_clr), .halt(halt)
   );

   assign debug_active = ~idle;

   dbg_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .clr(ige_clr), .wr(ige_wr), .wdata(ige_wdata),
      .active(debug_active), .irq_req(irq_req), .ige(ige), .irq_grant(irq_grant)
   );

   dbg_clk_gate #(.NUM_TIMERS(NUM_TIMERS)) u_gate (
      .active(debug_active), .tmr_en(tmr_clk_en), .wdt_en(wdt_clk_en)
   );
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
   parameter int AW         = 16,
   parameter int NUM_TIMERS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_dbg_req,
   input logic                  bkpt_hit,
   input logic                  resume,
   input logic                  debug_active,
   input logic                  fetch_block,
   input logic                  stk_push,
   input logic                  ip_load,
   input logic [AW-1:0]         ip_value,
   input logic                  ige_clr,
   input logic                  ige,
   input logic                  irq_req,
   input logic                  irq_grant,
   input logic                  halt,
   input logic [NUM_TIMERS-1:0] tmr_clk_en,
   input logic                  wdt_clk_en
);
   AST_ENTRY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!debug_active && (host_dbg_req || bkpt_hit)) |=> (debug_active && fetch_block)); // R1
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_block, stk_push, ip_load, ige_clr, halt})); // R2
   AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_block |=> (stk_push && !fetch_block)); // R3
   AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |=> (ip_load && ip_value == AW'(16'h8010))); // R4
   AST_IGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ige_clr |=> (!ige && halt)); // R5
   AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !resume) |=> (halt && !stk_push)); // R6
   AST_CLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      debug_active |-> (tmr_clk_en == '0 && !wdt_clk_en)); // R7
   AST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      debug_active |-> !irq_grant); // R8
   AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && resume) |=> (!debug_active && !ige && (&tmr_clk_en) && wdt_clk_en)); // R9
   AST_EARLY_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (ip_load && resume) |=> ige_clr); // R9
   AST_GRANT_COND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_grant |-> (irq_req && ige)); // R8
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.AW(AW), .NUM_TIMERS(NUM_TIMERS)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_dbg_req(host_dbg_req), .bkpt_hit(bkpt_hit),
   .resume(resume), .debug_active(debug_active), .fetch_block(fetch_block),
   .stk_push(stk_push), .ip_load(ip_load), .ip_value(ip_value),
   .ige_clr(ige_clr), .ige(ige), .irq_req(irq_req), .irq_grant(irq_grant),
   .halt(halt), .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en)
);

// File: tb/dbg_entry_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_tb;
   localparam int AW = 16;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_dbg_req = 0, bkpt_hit = 0, resume = 0, ige_wr = 0, ige_wdata = 0, irq_req = 0;
   logic [AW-1:0] pc_next = '0;
   logic debug_active, fetch_block, stk_push, ip_load, ige_clr, ige, irq_grant, halt, wdt_clk_en;
   logic [AW-1:0] stk_wdata, ip_value;
   logic [NT-1:0] tmr_clk_en;

   int checks = 0;
   int failures = 0;
   int push_cnt = 0;

   always #10 clk = ~clk;

   dbg_entry_ctrl #(.AW(AW), .NUM_TIMERS(NT)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_dbg_req(host_dbg_req), .bkpt_hit(bkpt_hit),
      .resume(resume), .pc_next(pc_next), .ige_wr(ige_wr), .ige_wdata(ige_wdata),
      .irq_req(irq_req), .debug_active(debug_active), .fetch_block(fetch_block),
      .stk_push(stk_push), .stk_wdata(stk_wdata), .ip_load(ip_load),
      .ip_value(ip_value), .ige_clr(ige_clr), .ige(ige), .irq_grant(irq_grant),
      .halt(halt), .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en)
   );

   always @(negedge clk) if (rst_n && stk_push) push_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_ige(input logic v);
      @(negedge clk); ige_wr = 1; ige_wdata = v;
      @(negedge clk); ige_wr = 0;
      chk("R11 ige write", 32'(ige), 32'(v));
   endtask

   // trigger sampled at the next edge, then each step checked one edge apart
   task automatic enter(input logic h, input logic b, input logic [AW-1:0] pc, input string tag);
      @(negedge clk); host_dbg_req = h; bkpt_hit = b; pc_next = pc;
      @(negedge clk); host_dbg_req = 0; bkpt_hit = 0; pc_next = ~pc;
      chk({"R1 active ", tag}, 32'(debug_active), 32'd1);
      chk({"R1 fetch_block ", tag}, 32'(fetch_block), 32'd1);
      chk({"R7 clk gated ", tag}, 32'({tmr_clk_en, wdt_clk_en}), 32'd0);
      @(negedge clk);
      chk({"R3 push ", tag}, 32'({stk_push, fetch_block}), 32'b10);
      chk({"R3 ret addr ", tag}, 32'(stk_wdata), 32'(pc));
      @(negedge clk);
      chk({"R4 ip_load ", tag}, 32'({ip_load, stk_push}), 32'b10);
      chk({"R4 vector ", tag}, 32'(ip_value), 32'h8010);
      @(negedge clk);
      chk({"R5 ige_clr ", tag}, 32'({ige_clr, halt}), 32'b10);
      @(negedge clk);
      chk({"R5 halt ", tag}, 32'(halt), 32'd1);
      chk({"R5 ige zero ", tag}, 32'(ige), 32'd0);
   endtask

   task automatic do_resume(input string tag);
      @(negedge clk); resume = 1;
      @(negedge clk); resume = 0;
      chk({"R9 exit ", tag}, 32'({debug_active, halt}), 32'd0);
      chk({"R9 clocks on ", tag}, 32'({tmr_clk_en, wdt_clk_en}), 32'h1F);
      chk({"R9 ige kept 0 ", tag}, 32'(ige), 32'd0);
   endtask

   task automatic t_reset;
      chk("R10 reset outputs", 32'({debug_active, halt, fetch_block, stk_push, ip_load, ige_clr, ige}), 32'd0);
      chk("R10 reset clocks", 32'({tmr_clk_en, wdt_clk_en}), 32'h1F);
   endtask

   task automatic t_host_entry;
      int p0;
      set_ige(1);
      irq_req = 1;
      #1 chk("R8 grant in run", 32'(irq_grant), 32'd1);
      p0 = push_cnt;
      enter(1, 0, 16'h1234, "host");
      chk("R8 no grant in debug", 32'(irq_grant), 32'd0);
      chk("R3 one push host", 32'(push_cnt - p0), 32'd1);
      do_resume("host");
      chk("R8 no grant after resume", 32'(irq_grant), 32'd0);
      irq_req = 0;
   endtask

   task automatic t_bkpt_entry;
      enter(0, 1, 16'hBEEF, "bkpt");
      do_resume("bkpt");
   endtask

   task automatic t_both;
      int p0;
      p0 = push_cnt;
      enter(1, 1, 16'h0A5A, "both");
      repeat (3) @(negedge clk);
      chk("R2 single push", 32'(push_cnt - p0), 32'd1);
      do_resume("both");
   endtask

   task automatic t_retrig;
      int p0;
      enter(1, 0, 16'h4321, "retrig");
      p0 = push_cnt;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); host_dbg_req = i[0]; bkpt_hit = ~i[0];
      end
      @(negedge clk); host_dbg_req = 0; bkpt_hit = 0;
      @(negedge clk);
      chk("R6 halt held", 32'({halt, fetch_block}), 32'b10);
      chk("R6 no push", 32'(push_cnt - p0), 32'd0);
      do_resume("retrig");
   endtask

   task automatic t_early_resume;
      @(negedge clk); host_dbg_req = 1; pc_next = 16'h0777;
      @(negedge clk); host_dbg_req = 0; resume = 1;
      @(negedge clk);
      chk("R9 early resume push", 32'(stk_push), 32'd1);
      @(negedge clk);
      chk("R9 early resume ip", 32'(ip_load), 32'd1);
      @(negedge clk); resume = 0;
      chk("R9 early resume active", 32'(debug_active), 32'd1);
      @(negedge clk);
      chk("R9 early resume halt", 32'(halt), 32'd1);
      do_resume("late");
   endtask

   task automatic t_clr_priority;
      set_ige(0);
      @(negedge clk); host_dbg_req = 1;
      @(negedge clk); host_dbg_req = 0;
      repeat (2) @(negedge clk);
      @(negedge clk); ige_wr = 1; ige_wdata = 1;
      chk("R11 clear step", 32'(ige_clr), 32'd1);
      @(negedge clk); ige_wr = 0;
      chk("R11 clear wins", 32'(ige), 32'd0);
      do_resume("prio");
      set_ige(1);
      set_ige(0);
   endtask

   initial begin
      #1_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_host_entry();
      t_bkpt_entry();
      t_both();
      t_retrig();
      t_early_resume();
      t_clr_priority();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule